// File: doc/BRIEF.md
# Pipelined NAND Write-Ahead Sequencer

This block sits in front of the page-program engine of a NAND flash controller. It keeps the bookkeeping for pre-announced page writes. The host first latches a starting block and page with an address write. It then sends a setup control word that announces how many consecutive pages it will stream into that block. Accepted announcements wait in a small in-order queue. After that the host sends one page-write data command per page. The sequencer checks each one against the next page that the oldest announcement still expects. A write that matches is serviced in pipelined form. A write that does not match is still serviced, as a plain single-page write, but it wipes out every pending announcement.

The sequencer pops an announcement when the write for its last page is issued, which is before that page's data is loaded. At that moment it raises a command-done interrupt, so the host can send the next announcement early. Later, the program engine reports each page's result on a status strobe. A passing result for the final page of a popped announcement raises a program-complete interrupt. Any failing result raises a program-fail interrupt and stores the failing address. All interrupts are sticky and are cleared by writing one to the matching bit.

Top module: `nwa_seq`

## Requirements
- R1: After reset, `irq` is 0, `q_count` is 0, `seq_idle` is 1 and `svc_valid` is 0.
- R2: A setup word is accepted when its upper byte is 0x21 (upper nibble 2 marks a pipelined request, lower nibble 1 selects the write direction), its low byte (the page count) is non-zero, the page span fits in the block and the queue is not full. The command then takes the block and page of the most recent address write, and `q_count` rises by one on the next cycle.
- R3: A setup word is rejected when its upper byte is not 0x21, its count is zero, or start page plus count exceeds PAGES_PER_BLK. A rejected word sets `irq` bit 0 (unsupported) and leaves `q_count` unchanged. A span that ends exactly at the block end is accepted.
- R4: A data write whose block and page equal the oldest queued command's start page plus the number of pages already consumed is serviced in pipelined form. This shows as `svc_valid`=1 and `svc_pipe`=1, with the same address, one cycle later.
- R5: While the queue is non-empty, a data write that does not match the expected page sets `irq` bit 1 (pipeline error) and empties the queue. The write is still serviced one cycle later with `svc_pipe`=0.
- R6: Queued commands are consumed strictly in issue order. The write for a command's last page pops that command and sets `irq` bit 2 (command done) in the same cycle that its service appears.
- R7: A passing program status for the final page of a popped command sets `irq` bit 3 (program complete). A passing status for any other page does not set it.
- R8: A data write while the queue is empty is serviced with `svc_pipe`=0 and raises no interrupt.
- R9: Interrupt bits stay set until a one is written to the same bit of `irq_clr`. Clearing one bit leaves the others unchanged.
- R10: With QDEPTH commands queued, a further valid setup word is refused with `irq` bit 0, and `q_count` stays at QDEPTH.
- R11: A failing program status sets `irq` bit 4 and stores its block and page in `err_blk` and `err_page` on the next cycle.
- R12: `seq_idle` is 1 exactly when no pre-announced page remains unconsumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Start-address write strobe |
| addr_blk | input | BLK_W | Start block |
| addr_page | input | log2(PAGES_PER_BLK) | Start page in block |
| setup_valid | input | 1 | Setup control word strobe |
| setup_word | input | 16 | Opcode byte above page count byte |
| wr_valid | input | 1 | Page-write data command strobe |
| wr_blk | input | BLK_W | Block targeted by the write |
| wr_page | input | log2(PAGES_PER_BLK) | Page targeted by the write |
| prog_valid | input | 1 | Per-page program result strobe |
| prog_fail | input | 1 | Result is a failure |
| prog_blk | input | BLK_W | Block of the reported page |
| prog_page | input | log2(PAGES_PER_BLK) | Page of the reported page |
| irq_clr | input | 5 | Write-one-to-clear for interrupt bits |
| irq | output | 5 | Sticky interrupts: 0 unsupported, 1 pipeline error, 2 command done, 3 program complete, 4 program fail |
| svc_valid | output | 1 | A write is being serviced |
| svc_pipe | output | 1 | Serviced write is pipelined (1) or plain (0) |
| svc_blk | output | BLK_W | Serviced block |
| svc_page | output | log2(PAGES_PER_BLK) | Serviced page |
| err_blk | output | BLK_W | Block of last failed program |
| err_page | output | log2(PAGES_PER_BLK) | Page of last failed program |
| seq_idle | output | 1 | No pre-announced page outstanding |
| q_count | output | log2(QDEPTH+1) | Queued commands |

## Verification
The properties assume that address, setup, data-write and clear strobes never arrive in the same cycle. Under that assumption, a rejected setup word is the only event that can touch the queue count in its cycle. The properties also assume the program engine reports each popped command's final page once, in issue order. The stimulus drives one strobe per cycle from tasks, and it issues program results only for pages it has written. Queue-full, block-end and out-of-order cases are therefore reached without overlapping events.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

    localparam logic [7:0] SETUP_WRITE_AHEAD = 8'h21;
    localparam int IRQ_N     = 5;
    localparam int IRQ_UNSUP = 0;
    localparam int IRQ_PERR  = 1;
    localparam int IRQ_CDONE = 2;
    localparam int IRQ_PDONE = 3;
    localparam int IRQ_PFAIL = 4;

    typedef enum logic [1:0] {
        SETUP_OK,
        SETUP_BAD_OP,
        SETUP_BAD_SPAN,
        SETUP_FULL
    } setup_verdict_e;

    // Opcode first, then span, then room in the queue.
    function automatic setup_verdict_e judge_setup(
        input logic [15:0] word,
        input int unsigned start_pg,
        input int unsigned ppb,
        input logic        full
    );
        int unsigned cnt;
        cnt = 32'(word[7:0]);
        if (word[15:8] != SETUP_WRITE_AHEAD) return SETUP_BAD_OP;
        if (cnt == 0 || start_pg + cnt > ppb) return SETUP_BAD_SPAN;
        if (full) return SETUP_FULL;
        return SETUP_OK;
    endfunction

endpackage

// File: rtl/nwa_fifo.sv
module nwa_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_push = push && (count != CW'(DEPTH)) && !flush;
    assign do_pop  = pop && (count != '0) && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/nwa_setup_dec.sv
module nwa_setup_dec
    import nwa_pkg::*;
#(
    parameter int PAGES_PER_BLK = 64,
    parameter int PG_W          = $clog2(PAGES_PER_BLK)
) (
    input  logic [15:0]     word,
    input  logic [PG_W-1:0] start_page,
    input  logic            full,
    output setup_verdict_e  verdict
);
    always_comb begin
        verdict = judge_setup(word, 32'(start_page), PAGES_PER_BLK, full);
    end
endmodule

// File: rtl/nwa_irq_bank.sv
module nwa_irq_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irq
);
    // A new event in the same cycle as a clear keeps its bit set.
    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= (irq & ~clr) | set;
    end
endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
    import nwa_pkg::*;
#(
    parameter int PAGES_PER_BLK = 64,
    parameter int QDEPTH        = 4,
    parameter int BLK_W         = 10
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 addr_valid,
    input  logic [BLK_W-1:0]                     addr_blk,
    input  logic [$clog2(PAGES_PER_BLK)-1:0]     addr_page,
    input  logic                                 setup_valid,
    input  logic [15:0]                          setup_word,
    input  logic                                 wr_valid,
    input  logic [BLK_W-1:0]                     wr_blk,
    input  logic [$clog2(PAGES_PER_BLK)-1:0]     wr_page,
    input  logic                                 prog_valid,
    input  logic                                 prog_fail,
    input  logic [BLK_W-1:0]                     prog_blk,
    input  logic [$clog2(PAGES_PER_BLK)-1:0]     prog_page,
    input  logic [4:0]                           irq_clr,
    output logic [4:0]                           irq,
    output logic                                 svc_valid,
    output logic                                 svc_pipe,
    output logic [BLK_W-1:0]                     svc_blk,
    output logic [$clog2(PAGES_PER_BLK)-1:0]     svc_page,
    output logic [BLK_W-1:0]                     err_blk,
    output logic [$clog2(PAGES_PER_BLK)-1:0]     err_page,
    output logic                                 seq_idle,
    output logic [$clog2(QDEPTH+1)-1:0]          q_count
);
    localparam int PG_W = $clog2(PAGES_PER_BLK);
    localparam int QC_W = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [PG_W-1:0]  page;
        logic [7:0]       cnt;
    } wa_cmd_t;

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [PG_W-1:0]  page;
    } pg_addr_t;

    // Latched start address for the next setup word
    pg_addr_t        start_q;
    // Pages of the oldest command already consumed
    logic [7:0]      head_off;

    wa_cmd_t         head, push_cmd;
    pg_addr_t        done_head, done_in;
    logic [QC_W-1:0] done_count;
    logic            q_full, q_empty, done_full, done_empty;
    setup_verdict_e  verdict;

    logic            wr_hit, wr_miss, head_last, cmd_pop, cmd_push;
    logic            done_match;
    logic [PG_W:0]   exp_page;
    logic [IRQ_N-1:0] irq_set;

    assign q_full     = (q_count == QC_W'(QDEPTH));
    assign q_empty    = (q_count == '0);
    assign done_full  = (done_count == QC_W'(QDEPTH));
    assign done_empty = (done_count == '0);

    nwa_setup_dec #(
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .PG_W          (PG_W)
    ) u_dec (
        .word       (setup_word),
        .start_page (start_q.page),
        .full       (q_full),
        .verdict    (verdict)
    );

    // Ordering check against the oldest queued command
    always_comb begin
        exp_page  = {1'b0, head.page} + (PG_W+1)'(head_off);
        head_last = (head_off == head.cnt - 8'd1);
        wr_hit    = wr_valid && !q_empty && (wr_blk == head.blk) &&
                    (exp_page == {1'b0, wr_page});
        wr_miss   = wr_valid && !q_empty && !wr_hit;
        cmd_pop   = wr_hit && head_last;
        cmd_push  = setup_valid && (verdict == SETUP_OK);
        push_cmd  = '{blk: start_q.blk, page: start_q.page, cnt: setup_word[7:0]};
        done_in   = '{blk: wr_blk, page: wr_page};
        done_match = prog_valid && !done_empty &&
                     (prog_blk == done_head.blk) && (prog_page == done_head.page);
    end

    nwa_fifo #(
        .W     ($bits(wa_cmd_t)),
        .DEPTH (QDEPTH)
    ) u_cmdq (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_push),
        .pop   (cmd_pop),
        .flush (wr_miss),
        .din   (push_cmd),
        .dout  (head),
        .count (q_count)
    );

    // Final pages waiting for their program result, in pop order
    nwa_fifo #(
        .W     ($bits(pg_addr_t)),
        .DEPTH (QDEPTH)
    ) u_doneq (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_pop && !done_full),
        .pop   (done_match),
        .flush (1'b0),
        .din   (done_in),
        .dout  (done_head),
        .count (done_count)
    );

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_UNSUP] = setup_valid && (verdict != SETUP_OK);
        irq_set[IRQ_PERR]  = wr_miss;
        irq_set[IRQ_CDONE] = cmd_pop;
        irq_set[IRQ_PDONE] = done_match && !prog_fail;
        irq_set[IRQ_PFAIL] = prog_valid && prog_fail;
    end

    nwa_irq_bank #(.N(IRQ_N)) u_irq (
        .clk (clk),
        .rst (rst),
        .set (irq_set),
        .clr (irq_clr),
        .irq (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= '0;
            head_off  <= '0;
            svc_valid <= 1'b0;
            svc_pipe  <= 1'b0;
            svc_blk   <= '0;
            svc_page  <= '0;
            err_blk   <= '0;
            err_page  <= '0;
        end else begin
            if (addr_valid) start_q <= '{blk: addr_blk, page: addr_page};
            if (wr_miss || cmd_pop) head_off <= '0;
            else if (wr_hit)        head_off <= head_off + 8'd1;
            svc_valid <= wr_valid;
            svc_pipe  <= wr_hit;
            if (wr_valid) begin
                svc_blk  <= wr_blk;
                svc_page <= wr_page;
            end
            if (prog_valid && prog_fail) begin
                err_blk  <= prog_blk;
                err_page <= prog_page;
            end
        end
    end

    assign seq_idle = q_empty;

endmodule

// File: rtl/nwa_seq_chk.sv
module nwa_seq_chk #(
    parameter int PAGES_PER_BLK = 64,
    parameter int QDEPTH        = 4,
    parameter int BLK_W         = 10
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              setup_valid,
    input logic [15:0]                       setup_word,
    input logic                              wr_valid,
    input logic                              prog_valid,
    input logic                              prog_fail,
    input logic [BLK_W-1:0]                  prog_blk,
    input logic [$clog2(PAGES_PER_BLK)-1:0]  prog_page,
    input logic [4:0]                        irq_clr,
    input logic [4:0]                        irq,
    input logic                              svc_valid,
    input logic [BLK_W-1:0]                  err_blk,
    input logic [$clog2(PAGES_PER_BLK)-1:0]  err_page,
    input logic                              seq_idle,
    input logic [$clog2(QDEPTH+1)-1:0]       q_count
);
    localparam int QC_W = $clog2(QDEPTH + 1);

    // R10
    queue_cap_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= QC_W'(QDEPTH));

    // R3
    bad_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        setup_valid && (setup_word[15:8] != 8'h21) |=> irq[0] && $stable(q_count));

    // R5
    flush_on_error_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[1]) |-> seq_idle && (q_count == '0));

    // R4
    write_serviced_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> svc_valid);

    // R8
    service_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> $past(wr_valid));

    // R6
    done_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[2]) |-> $past(wr_valid));

    // R9
    sticky_irq_chk: assert property (@(posedge clk) disable iff (rst)
        &(~$past(irq) | $past(irq_clr) | irq));

    // R11
    fail_capture_chk: assert property (@(posedge clk) disable iff (rst)
        prog_valid && prog_fail |=> irq[4] && (err_blk == $past(prog_blk)) &&
                                    (err_page == $past(prog_page)));

    // R12
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        seq_idle == (q_count == '0));

endmodule

bind nwa_seq nwa_seq_chk #(
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .QDEPTH        (QDEPTH),
    .BLK_W         (BLK_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .setup_valid (setup_valid),
    .setup_word  (setup_word),
    .wr_valid    (wr_valid),
    .prog_valid  (prog_valid),
    .prog_fail   (prog_fail),
    .prog_blk    (prog_blk),
    .prog_page   (prog_page),
    .irq_clr     (irq_clr),
    .irq         (irq),
    .svc_valid   (svc_valid),
    .err_blk     (err_blk),
    .err_page    (err_page),
    .seq_idle    (seq_idle),
    .q_count     (q_count)
);

// File: tb/sim_nwa_seq.sv
`timescale 1ns/1ps
module sim_nwa_seq;
    localparam int PPB   = 64;
    localparam int QD    = 4;
    localparam int BW    = 10;
    localparam int PW    = $clog2(PPB);
    localparam int QCW   = $clog2(QD + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_valid = 0, setup_valid = 0, wr_valid = 0, prog_valid = 0, prog_fail = 0;
    logic [BW-1:0] addr_blk = '0, wr_blk = '0, prog_blk = '0;
    logic [PW-1:0] addr_page = '0, wr_page = '0, prog_page = '0;
    logic [15:0]   setup_word = '0;
    logic [4:0]    irq_clr = '0;
    logic [4:0]    irq;
    logic          svc_valid, svc_pipe, seq_idle;
    logic [BW-1:0] svc_blk, err_blk;
    logic [PW-1:0] svc_page, err_page;
    logic [QCW-1:0] q_count;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct packed {
        logic          pipe;
        logic [BW-1:0] blk;
        logic [PW-1:0] page;
    } svc_item_t;
    svc_item_t sb[$];

    always #2.5 clk = ~clk;

    nwa_seq #(.PAGES_PER_BLK(PPB), .QDEPTH(QD), .BLK_W(BW)) u0 (
        .clk(clk), .rst(rst),
        .addr_valid(addr_valid), .addr_blk(addr_blk), .addr_page(addr_page),
        .setup_valid(setup_valid), .setup_word(setup_word),
        .wr_valid(wr_valid), .wr_blk(wr_blk), .wr_page(wr_page),
        .prog_valid(prog_valid), .prog_fail(prog_fail),
        .prog_blk(prog_blk), .prog_page(prog_page),
        .irq_clr(irq_clr), .irq(irq),
        .svc_valid(svc_valid), .svc_pipe(svc_pipe),
        .svc_blk(svc_blk), .svc_page(svc_page),
        .err_blk(err_blk), .err_page(err_page),
        .seq_idle(seq_idle), .q_count(q_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each serviced write against the scoreboard
    always @(negedge clk) begin
        if (!rst && svc_valid) begin
            if (sb.size() == 0) begin
                check("R4/R8 unexpected service", 32'(svc_blk), 32'hFFFF_FFFF);
            end else begin
                svc_item_t e;
                e = sb.pop_front();
                check("R4/R5/R8 svc_pipe", 32'(svc_pipe), 32'(e.pipe));
                check("R4 svc_blk", 32'(svc_blk), 32'(e.blk));
                check("R4 svc_page", 32'(svc_page), 32'(e.page));
            end
        end
    end

    task automatic do_addr(input int b, input int p);
        @(negedge clk);
        addr_valid = 1; addr_blk = BW'(b); addr_page = PW'(p);
        @(negedge clk);
        addr_valid = 0;
    endtask

    task automatic do_setup(input logic [15:0] w);
        @(negedge clk);
        setup_valid = 1; setup_word = w;
        @(negedge clk);
        setup_valid = 0;
    endtask

    task automatic do_write(input int b, input int p, input logic exp_pipe);
        svc_item_t e;
        e.pipe = exp_pipe; e.blk = BW'(b); e.page = PW'(p);
        sb.push_back(e);
        @(negedge clk);
        wr_valid = 1; wr_blk = BW'(b); wr_page = PW'(p);
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic do_prog(input int b, input int p, input logic fail);
        @(negedge clk);
        prog_valid = 1; prog_fail = fail; prog_blk = BW'(b); prog_page = PW'(p);
        @(negedge clk);
        prog_valid = 0; prog_fail = 0;
    endtask

    task automatic do_clr(input logic [4:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 q_count", 32'(q_count), 0);
        check("R1 seq_idle", 32'(seq_idle), 1);
        check("R1 svc_valid", 32'(svc_valid), 0);

        // R2 accepted setup: block 5, page 10, three pages
        do_addr(5, 10);
        do_setup(16'h2103);
        check("R2 q_count", 32'(q_count), 1);
        check("R12 busy", 32'(seq_idle), 0);
        check("R2 no irq", 32'(irq), 0);

        // R4 / R6 in-order consumption, pop on last page
        do_write(5, 10, 1);
        do_write(5, 11, 1);
        check("R6 no early done", 32'(irq[2]), 0);
        do_write(5, 12, 1);
        check("R6 done on last page", 32'(irq[2]), 1);
        check("R6 popped", 32'(q_count), 0);
        check("R12 idle again", 32'(seq_idle), 1);

        // R7 program complete only for the final page
        do_prog(5, 11, 0);
        check("R7 not final page", 32'(irq[3]), 0);
        do_prog(5, 12, 0);
        check("R7 final page", 32'(irq[3]), 1);

        // R9 clear one bit, others remain
        do_clr(5'b00100);
        check("R9 partial clear", 32'(irq), 32'b01000);
        do_clr(5'b11111);
        check("R9 full clear", 32'(irq), 0);

        // R3 span crossing the block end
        do_addr(7, 62);
        do_setup(16'h2103);
        check("R3 span unsup", 32'(irq[0]), 1);
        check("R3 span q_count", 32'(q_count), 0);
        do_clr(5'b00001);
        // R3 span ending exactly at the block end
        do_setup(16'h2102);
        check("R3 exact fit accepted", 32'(q_count), 1);
        check("R3 exact fit no irq", 32'(irq[0]), 0);
        do_write(7, 62, 1);
        do_write(7, 63, 1);
        check("R3 exact fit consumed", 32'(q_count), 0);
        // R3 wrong opcode and zero count
        do_setup(16'h3102);
        check("R3 bad opcode", 32'(irq[0]), 1);
        do_clr(5'b00001);
        do_addr(8, 0);
        do_setup(16'h2100);
        check("R3 zero count", 32'(irq[0]), 1);
        check("R3 zero count q_count", 32'(q_count), 0);
        do_clr(5'b11111);

        // R5 write to a later command before the first completes
        do_addr(1, 0);
        do_setup(16'h2102);
        do_addr(2, 4);
        do_setup(16'h2102);
        check("R2 two queued", 32'(q_count), 2);
        do_write(2, 4, 0);
        check("R5 pipe error", 32'(irq[1]), 1);
        check("R5 queue flushed", 32'(q_count), 0);
        do_clr(5'b11111);

        // R6 two commands consumed in issue order
        do_addr(1, 0);
        do_setup(16'h2102);
        do_addr(2, 4);
        do_setup(16'h2102);
        do_write(1, 0, 1);
        do_write(1, 1, 1);
        check("R6 first popped", 32'(q_count), 1);
        do_clr(5'b00100);
        do_write(2, 4, 1);
        do_write(2, 5, 1);
        check("R6 second done", 32'(irq[2]), 1);
        check("R6 order no error", 32'(irq[1]), 0);
        check("R6 second popped", 32'(q_count), 0);
        do_clr(5'b11111);

        // R8 write with nothing queued
        do_write(20, 7, 0);
        check("R8 no irq", 32'(irq), 0);

        // R10 queue full refuses a further setup
        for (int i = 0; i < QD; i++) begin
            do_addr(3, i);
            do_setup(16'h2101);
        end
        check("R10 full", 32'(q_count), QD);
        do_addr(3, 10);
        do_setup(16'h2101);
        check("R10 refused unsup", 32'(irq[0]), 1);
        check("R10 count held", 32'(q_count), QD);
        do_write(9, 9, 0);
        check("R5 flush from full", 32'(q_count), 0);
        do_clr(5'b11111);

        // R11 program failure latches the address
        do_prog(9, 3, 1);
        check("R11 fail irq", 32'(irq[4]), 1);
        check("R11 err_blk", 32'(err_blk), 9);
        check("R11 err_page", 32'(err_page), 3);

        repeat (3) @(negedge clk);
        check("R4 scoreboard drained", 32'(sb.size()), 0);
        finish_run();
    end
endmodule